// File: doc/BRIEF.md
# Interval Timer with Power-State Handling

This block is an up-counting interval timer. Once enabled it counts from zero to a programmable compare value, wraps back to zero, and starts the next period. Each wrap is a compare match. A match raises a sticky interrupt flag and, if output is enabled, toggles an output pin, so the pin carries a square wave whose half-period is one timer period. The flag stays set until software clears it with a one-cycle strobe.

The timer also follows the chip's power states. Sleep does not stop it, so its flag can wake a sleeping system. A stop request freezes the counter at its current value. A wake input leaves the stop state. Counting then resumes from the frozen value once an external settle-done input is seen, so the first period after stop is shorter than programmed. During stop the pin is either released (driver off) or kept at the level it had on entry, depending on a select bit. Clearing the enable bit halts the timer and drives the pin low.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. The tri-state pin is modelled as a level plus a driver-enable.

Top module: `ivl_timer`

## Requirements
- R1: While running, the counter advances by one on each clock edge. On the edge where it equals `cmp_val` it returns to 0, so matches occur every `cmp_val`+1 cycles.
- R2: A match sets `irq_flag`. The flag stays at 1 until an edge with `flag_clr`=1, which clears it. A match on that same edge wins, and the flag stays 1.
- R3: While `run_en`=0 the counter does not move, no match occurs, and `pin_o` is 0 (outside stop).
- R4: The first edge after `run_en` goes 0 to 1 loads the counter with 0 and resets the toggle state to 0. The first match comes `cmp_val`+1 edges after that edge.
- R5: With `out_en`=1 the pin level toggles on each match. With `out_en`=0 the pin reads 0 and the toggle state does not change.
- R6: `stop_req`=1 in the running state enters stop on the next edge. The counter does not advance on that edge or during stop. With `hiz_sel`=0 the pin keeps the level it had on entry, even if `out_en` changes.
- R7: With `hiz_sel`=1, `pin_oe` is 0 throughout stop. Outside stop `pin_oe` is 1.
- R8: `wake`=1 during stop leaves stop on the next edge and enters a settle state in which the counter is held. `settle_done`=1 in settle returns to running on the next edge. Counting continues from the frozen value on the edge after that.
- R9: `sleep_req` has no effect. Counting, matches and the pin behave identically with it at 1.
- R10: With `cmp_val`=0 every running edge is a match, so the flag is set every cycle and the pin toggles every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Timer enable; rising level restarts the count |
| cmp_val | input | W | Compare value (period is cmp_val+1) |
| out_en | input | 1 | Allows the pin to toggle on matches |
| hiz_sel | input | 1 | 1: release the pin during stop; 0: hold its level |
| sleep_req | input | 1 | Sleep state indication (timer keeps running) |
| stop_req | input | 1 | Request to enter stop |
| wake | input | 1 | Leaves stop |
| settle_done | input | 1 | Clock settled; counting may resume |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| irq_flag | output | 1 | Sticky match flag |
| pin_o | output | 1 | Pin level |
| pin_oe | output | 1 | Pin driver enable (0 = high impedance) |

## Verification
The main function is driven with compare values of 3, 7 and 0, and the match edges are located through the flag and the pin toggles. This tells a correct period apart from an off-by-one and shows that the every-cycle case works. A restart after a mid-period halt is compared with a resume after stop: the first must take the full period, the second only the remainder from the frozen count, which separates clearing from holding. Running the same stimulus with sleep asserted shows it has no influence. Changing the output enable while stopped, with each setting of the select bit, separates a held pin level from a live one and from a released pin.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_STOP   = 2'd1,
    PS_SETTLE = 2'd2
  } pstate_e;
endpackage

// File: rtl/ivt_power.sv
module ivt_power
  import ivt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic settle_done,
  output logic in_stop,
  output logic enter_stop,
  output logic may_count
);
  pstate_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_RUN:    if (stop_req)    st_d = PS_STOP;
      PS_STOP:   if (wake)        st_d = PS_SETTLE;
      PS_SETTLE: if (settle_done) st_d = PS_RUN;
      default:                    st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_RUN;
    else        st_q <= st_d;
  end

  assign in_stop    = (st_q == PS_STOP);
  assign enter_stop = (st_q == PS_RUN) && stop_req;
  assign may_count  = (st_q == PS_RUN) && !stop_req;
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         may_count,
  input  logic [W-1:0] cmp_val,
  output logic         start,
  output logic         active,
  output logic         match,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic ena_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= 1'b0;
    else        ena_q <= run_en;
  end

  assign start  = run_en && !ena_q;
  assign active = run_en && may_count && !start;
  assign match  = active && (cnt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= ZERO;
    else if (start)  cnt <= ZERO;
    else if (match)  cnt <= ZERO;
    else if (active) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/ivt_out.sv
module ivt_out (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic out_en,
  input  logic hiz_sel,
  input  logic start,
  input  logic match,
  input  logic in_stop,
  input  logic enter_stop,
  input  logic flag_clr,
  output logic irq_flag,
  output logic pin_o,
  output logic pin_oe
);
  logic tgl_q;
  logic frz_q;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tgl_q <= 1'b0;
    else if (start)           tgl_q <= 1'b0;
    else if (match && out_en) tgl_q <= !tgl_q;
  end

  assign live = run_en && out_en && tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frz_q <= 1'b0;
    else if (enter_stop) frz_q <= live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (match)    irq_flag <= 1'b1;
    else if (flag_clr) irq_flag <= 1'b0;
  end

  always_comb begin
    pin_oe = !(in_stop && hiz_sel);
    if (!pin_oe)      pin_o = 1'b0;
    else if (in_stop) pin_o = frz_q;
    else              pin_o = live;
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic [W-1:0] cmp_val,
  input  logic         out_en,
  input  logic         hiz_sel,
  input  logic         sleep_req,
  input  logic         stop_req,
  input  logic         wake,
  input  logic         settle_done,
  input  logic         flag_clr,
  output logic         irq_flag,
  output logic         pin_o,
  output logic         pin_oe
);
  logic         in_stop, enter_stop, may_count;
  logic         start, active, match;
  logic [W-1:0] cnt;
  logic         sleep_seen;

  // sleep state leaves the timer running; kept only as an observed input
  assign sleep_seen = sleep_req;

  ivt_power u_power (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .wake        (wake),
    .settle_done (settle_done),
    .in_stop     (in_stop),
    .enter_stop  (enter_stop),
    .may_count   (may_count)
  );

  ivt_count #(.W(W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .may_count (may_count),
    .cmp_val   (cmp_val),
    .start     (start),
    .active    (active),
    .match     (match),
    .cnt       (cnt)
  );

  ivt_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .out_en     (out_en),
    .hiz_sel    (hiz_sel),
    .start      (start),
    .match      (match),
    .in_stop    (in_stop),
    .enter_stop (enter_stop),
    .flag_clr   (flag_clr),
    .irq_flag   (irq_flag),
    .pin_o      (pin_o),
    .pin_oe     (pin_oe)
  );
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic [W-1:0] cmp_val,
  input logic         sleep_req,
  input logic         wake,
  input logic         flag_clr,
  input logic         irq_flag,
  input logic         pin_o,
  input logic         in_stop,
  input logic         active,
  input logic [W-1:0] cnt
);
  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && $past(!run_en)) |-> $stable(cnt));

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |=> (cnt == '0));

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && $past(in_stop)) |-> ($stable(cnt) && $stable(pin_o)));

  // R8
  wake_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && wake) |=> !in_stop);

  // R9
  sleep_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && active && (cnt != cmp_val)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

bind ivl_timer ivt_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .cmp_val   (cmp_val),
  .sleep_req (sleep_seen),
  .wake      (wake),
  .flag_clr  (flag_clr),
  .irq_flag  (irq_flag),
  .pin_o     (pin_o),
  .in_stop   (in_stop),
  .active    (active),
  .cnt       (cnt)
);

// File: tb/test_ivl_timer.sv
`timescale 1ns/1ps
module test_ivl_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 0, out_en = 0, hiz_sel = 0, sleep_req = 0;
  logic       stop_req = 0, wake = 0, settle_done = 0, flag_clr = 0;
  logic [7:0] cmp_val = 8'd0;
  logic       irq_flag, pin_o, pin_oe;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int    due;
    int    flg;
    int    pin;
    int    oe;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivl_timer i_ivl_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmp_val(cmp_val),
    .out_en(out_en), .hiz_sel(hiz_sel), .sleep_req(sleep_req),
    .stop_req(stop_req), .wake(wake), .settle_done(settle_done),
    .flag_clr(flag_clr), .irq_flag(irq_flag), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // push an expectation n samples ahead; -1 means don't care
  task automatic expect_at(int n, int f, int p, int o, string tag);
    exp_t e;
    int k;
    e.due = cyc + n; e.flg = f; e.pin = p; e.oe = o; e.tag = tag;
    k = 0;
    while (k < sb.size() && sb[k].due <= e.due) k++;
    sb.insert(k, e);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cmp1(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.flg >= 0) cmp1(e.tag, "irq_flag", int'(irq_flag), e.flg);
      if (e.pin >= 0) cmp1(e.tag, "pin_o", int'(pin_o), e.pin);
      if (e.oe  >= 0) cmp1(e.tag, "pin_oe", int'(pin_oe), e.oe);
    end
  end

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        expect_at(0, 0, 0, 1, "R1 reset");
        step(1);

        // R1 R4 R5: period of cmp+1 = 4
        cmp_val = 8'd3; out_en = 1; run_en = 1;
        expect_at(4, 0, 0, -1, "R4 first period");
        expect_at(5, 1, 1, -1, "R1 first match");
        expect_at(8, 1, 1, -1, "R5 pin held");
        expect_at(9, 1, 0, -1, "R5 toggle back");
        step(10);

        // R2: clear works, next match sets again
        expect_at(0, 1, -1, -1, "R2 sticky");
        flag_clr = 1;
        expect_at(1, 0, -1, -1, "R2 cleared");
        step(1);
        flag_clr = 0;
        expect_at(2, 1, 1, -1, "R2 set again");
        step(3);

        // R3: halt drives pin low, no matches
        run_en = 0;
        expect_at(0, -1, 0, 1, "R3 pin low on halt");
        flag_clr = 1;
        step(1);
        flag_clr = 0;
        expect_at(10, 0, 0, -1, "R3 no match while halted");
        step(11);

        // R4 R9: restart clears count; sleep has no effect
        sleep_req = 1;
        run_en = 1;
        expect_at(4, 0, 0, -1, "R9 R4 restart full period");
        expect_at(5, 1, 1, -1, "R9 R4 restart match");
        step(6);
        sleep_req = 0;

        // R5: out_en low forces pin 0
        out_en = 0;
        expect_at(0, -1, 0, -1, "R5 out_en off");
        expect_at(6, 1, 0, -1, "R5 out_en off still low");
        step(7);

        // R6 R8: stop with hold, resume from frozen count (cmp=7)
        run_en = 0; step(1);
        cmp_val = 8'd7; out_en = 1; hiz_sel = 0; run_en = 1;
        expect_at(9, -1, 1, -1, "R1 match cmp7");
        step(11);
        stop_req = 1;
        step(1);
        stop_req = 0;
        out_en = 0;
        expect_at(0, -1, 1, 1, "R6 held level");
        expect_at(5, -1, 1, 1, "R6 still held");
        step(5);
        wake = 1;
        step(1);
        wake = 0;
        out_en = 1;
        step(3);
        settle_done = 1;
        expect_at(6, -1, 1, -1, "R8 before shortened match");
        expect_at(7, -1, 0, -1, "R8 resume from frozen count");
        step(1);
        settle_done = 0;
        step(8);

        // R7: high impedance in stop
        hiz_sel = 1;
        stop_req = 1;
        step(1);
        stop_req = 0;
        expect_at(0, -1, -1, 0, "R7 released in stop");
        step(2);
        wake = 1;
        step(1);
        wake = 0;
        expect_at(0, -1, -1, 1, "R7 driven after wake");
        settle_done = 1;
        step(1);
        settle_done = 0;
        hiz_sel = 0;

        // R10: compare 0 matches every cycle
        run_en = 0;
        flag_clr = 1;
        step(1);
        flag_clr = 0;
        cmp_val = 8'd0; out_en = 1; run_en = 1;
        expect_at(1, 0, 0, -1, "R10 start");
        expect_at(2, 1, 1, -1, "R10 match 1");
        expect_at(3, 1, 0, -1, "R10 match 2");
        expect_at(4, 1, 1, -1, "R10 match 3");
        step(3);
        flag_clr = 1;
        expect_at(1, 1, -1, -1, "R2 set wins over clear");
        step(1);
        flag_clr = 0;
        step(3);
        if (sb.size() != 0) begin
          n_chk++; n_err++;
          $display("FAIL R1 pending expectations actual=%0d expected=0", sb.size());
        end
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule